// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block schedules refresh work for an asynchronous DRAM array. It holds off all traffic after reset for a fixed settling pause. It then asks the memory controller for a short burst of warm-up refresh cycles and raises a ready flag once they are done. From then on it requests one refresh per row interval, so that every row is refreshed within the retention window.

The controller answers each request with a grant pulse when it starts the refresh and a done pulse when the cycle has finished. Intervals that expire before the controller has answered are stored as credits, so that no refresh is lost while the controller is busy. For RAS-only refresh the block supplies a row address that steps after every completed refresh. Parts that use CAS-before-RAS refresh can build the block without this counter. Driving the RAS and CAS strobes is the controller's task.

The settling pause and the row interval come from package functions of clock frequency, pause length, retention window and row count. At 125 MHz these give 25000 cycles for the pause and 1953 cycles per row, in both the 4096-row/64 ms and the 2048-row/32 ms configurations.

Top module: `refresh_sched`

## Requirements
- R1: While reset is asserted and directly after it, `ref_req` is 0, `ready` is 0 and `ref_row` is 0.
- R2: `ref_req` stays 0 for the first PAUSE_CYC rising edges after reset release and is 1 after the PAUSE_CYC-th edge. Grant or done pulses during the pause change nothing.
- R3: After the pause, `ref_req` is raised again after each completion until exactly WARMUP refreshes have completed.
- R4: `ready` rises on the edge that registers the WARMUP-th completion and stays 1 until the next reset.
- R5: A grant while `ref_req` is 1 drops `ref_req` on the next edge and leaves one refresh in flight. A grant while `ref_req` is 0, or a done while no refresh is in flight, is ignored.
- R6: Once ready, one refresh credit is added every INTERVAL_CYC cycles, the first one INTERVAL_CYC edges after `ready` rises. `ref_req` is 1 whenever credits remain and no refresh is in flight.
- R7: Credits that have not been served add up to at most PEND_MAX. A completion removes one credit. A credit added on the same edge as a completion leaves the count unchanged.
- R8: `ref_row` advances by one on each completed refresh (warm-up included), modulo 2^ROW_BITS. With ROW_ADDR_EN=0 it stays 0.
- R9: The default pause is PAUSE_US x CLK_MHZ cycles. The default row interval is RETENTION_US x CLK_MHZ / 2^ROW_BITS cycles, rounded down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_grant | input | 1 | Controller starts the requested refresh (one-cycle pulse) |
| ref_done | input | 1 | Controller has finished the refresh in flight (one-cycle pulse) |
| ref_req | output | 1 | A refresh is wanted |
| ready | output | 1 | Warm-up finished; normal accesses allowed |
| ref_row | output | ROW_BITS | Row address for RAS-only refresh |

## Verification
The bench builds the block with a 20-cycle pause, a 12-cycle row interval, a 3-bit row counter and a credit limit of 3. With these values the whole power-up sequence, several intervals, credit saturation under a stalled controller and row-counter wrap all fit in a few hundred cycles. A second instance is built with the row counter left out, to show that its address stays at zero. The package functions are checked separately at their full-size defaults.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

  typedef enum logic [1:0] {
    PH_PAUSE = 2'd0,
    PH_WARM  = 2'd1,
    PH_RUN   = 2'd2
  } phase_t;

  // settling pause in clock cycles
  function automatic int unsigned us_to_cycles(int unsigned us, int unsigned clk_mhz);
    return us * clk_mhz;
  endfunction

  // even spacing of one refresh per row across the retention window
  function automatic int unsigned row_spacing_cycles(int unsigned retention_us,
                                                     int unsigned rows,
                                                     int unsigned clk_mhz);
    return (retention_us * clk_mhz) / rows;
  endfunction

endpackage

// File: rtl/ref_phase_ctrl.sv
module ref_phase_ctrl
  import refresh_pkg::*;
#(
  parameter int unsigned PAUSE_CYC = 25000,
  parameter int unsigned WARMUP    = 8
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   done_acc,
  output phase_t phase,
  output logic   warm_need
);
  localparam int PW = $clog2(PAUSE_CYC + 1);
  localparam int WW = $clog2(WARMUP + 1);

  logic [PW-1:0] pause_cnt;
  logic [WW-1:0] warm_left;
  logic          pause_done;
  logic          warm_last;

  assign pause_done = (phase == PH_PAUSE) && (pause_cnt == PW'(PAUSE_CYC - 1));
  assign warm_last  = (phase == PH_WARM) && done_acc && (warm_left == WW'(1));
  assign warm_need  = (phase == PH_WARM) && (warm_left != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_PAUSE;
      pause_cnt <= '0;
      warm_left <= '0;
    end else begin
      case (phase)
        PH_PAUSE: begin
          if (pause_done) begin
            phase     <= PH_WARM;
            warm_left <= WW'(WARMUP);
          end else begin
            pause_cnt <= pause_cnt + 1'b1;
          end
        end
        PH_WARM: begin
          if (done_acc) warm_left <= warm_left - 1'b1;
          if (warm_last) phase <= PH_RUN;
        end
        default: phase <= PH_RUN;
      endcase
    end
  end

  AST_PAUSE_NOT_REENTERED: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_PAUSE) |=> (phase != PH_PAUSE)); // R2
  AST_RUN_IS_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RUN) |=> (phase == PH_RUN)); // R4
  AST_WARM_ENDS_ON_LAST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_WARM) && $past(phase) == PH_WARM && $past(!done_acc)) |-> (warm_left == $past(warm_left))); // R3

endmodule

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int unsigned INTERVAL_CYC = 1953
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int TW = $clog2(INTERVAL_CYC + 1);

  logic [TW-1:0] cnt;

  assign tick = run && (cnt == TW'(INTERVAL_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (INTERVAL_CYC > 1)) |=> !tick); // R6
  AST_NO_TICK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0)); // R6

endmodule

// File: rtl/ref_handshake.sv
module ref_handshake #(
  parameter int unsigned PEND_MAX = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic warm_need,
  input  logic run,
  input  logic tick,
  input  logic grant,
  input  logic done,
  output logic req,
  output logic grant_acc,
  output logic done_acc
);
  localparam int CW = $clog2(PEND_MAX + 1);

  logic [CW-1:0] pend;
  logic          in_flight;
  logic          need;
  logic          dec;

  assign need      = warm_need || (run && (pend != '0));
  assign req       = need && !in_flight;
  assign grant_acc = grant && req;
  assign done_acc  = done && in_flight;
  assign dec       = done_acc && run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_flight <= 1'b0;
      pend      <= '0;
    end else begin
      if (grant_acc)     in_flight <= 1'b1;
      else if (done_acc) in_flight <= 1'b0;
      if (tick && !dec) begin
        if (pend != CW'(PEND_MAX)) pend <= pend + 1'b1;
      end else if (!tick && dec) begin
        pend <= pend - 1'b1;
      end
    end
  end

  AST_GRANT_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    grant_acc |=> !req); // R5
  AST_PEND_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend == CW'(PEND_MAX)) && tick && !dec) |=> (pend == CW'(PEND_MAX))); // R7
  AST_DONE_HAS_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (pend != '0)); // R7
  AST_IDLE_DONE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !in_flight && !grant_acc) |=> !in_flight); // R5

endmodule

// File: rtl/ref_row_ctr.sv
module ref_row_ctr #(
  parameter int unsigned ROW_BITS    = 12,
  parameter bit          ROW_ADDR_EN = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  output logic [ROW_BITS-1:0] row
);
  generate
    if (ROW_ADDR_EN) begin : g_ctr
      logic [ROW_BITS-1:0] row_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   row_q <= '0;
        else if (adv) row_q <= row_q + 1'b1;
      end
      assign row = row_q;

      AST_ROW_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (row == $past(row) + 1'b1)); // R8
      AST_ROW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(row)); // R8
    end else begin : g_none
      assign row = '0;
    end
  endgenerate

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refresh_pkg::*;
#(
  parameter int unsigned CLK_MHZ      = 125,
  parameter int unsigned PAUSE_US     = 200,
  parameter int unsigned RETENTION_US = 64000,
  parameter int unsigned ROW_BITS     = 12,
  parameter int unsigned WARMUP       = 8,
  parameter int unsigned PEND_MAX     = 3,
  parameter bit          ROW_ADDR_EN  = 1'b1,
  parameter int unsigned PAUSE_CYC    = us_to_cycles(PAUSE_US, CLK_MHZ),
  parameter int unsigned INTERVAL_CYC = row_spacing_cycles(RETENTION_US, 1 << ROW_BITS, CLK_MHZ)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ref_grant,
  input  logic                ref_done,
  output logic                ref_req,
  output logic                ready,
  output logic [ROW_BITS-1:0] ref_row
);
  phase_t phase;
  logic   warm_need;
  logic   run;
  logic   tick;
  logic   grant_acc;
  logic   done_acc;

  assign run   = (phase == PH_RUN);
  assign ready = run;

  ref_phase_ctrl #(.PAUSE_CYC(PAUSE_CYC), .WARMUP(WARMUP)) u_phase (
    .clk(clk), .rst_n(rst_n), .done_acc(done_acc),
    .phase(phase), .warm_need(warm_need)
  );

  ref_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  ref_handshake #(.PEND_MAX(PEND_MAX)) u_hs (
    .clk(clk), .rst_n(rst_n), .warm_need(warm_need), .run(run), .tick(tick),
    .grant(ref_grant), .done(ref_done),
    .req(ref_req), .grant_acc(grant_acc), .done_acc(done_acc)
  );

  ref_row_ctr #(.ROW_BITS(ROW_BITS), .ROW_ADDR_EN(ROW_ADDR_EN)) u_row (
    .clk(clk), .rst_n(rst_n), .adv(done_acc), .row(ref_row)
  );

  AST_QUIET_DURING_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PAUSE) |-> !ref_req); // R2
  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready); // R4
  AST_WARM_REQUESTS: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_need && $past(done_acc)) |-> ref_req); // R3

endmodule

// File: tb/refresh_sched_test.sv
module refresh_sched_test;
  import refresh_pkg::*;

  localparam int PAUSE_T = 20;
  localparam int INT_T   = 12;
  localparam int RB      = 3;
  localparam int WARM_T  = 8;
  localparam int PMAX    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_grant = 1'b0;
  logic ref_done = 1'b0;
  logic ref_req, ready, req_f, ready_f;
  logic [RB-1:0] ref_row, row_f;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int served = 0;

  // behavioural reference state
  int m_phase = 0;
  int m_pcnt = 0, m_warm = 0, m_tmr = 0, m_pend = 0, m_row = 0;
  bit m_fly = 0;

  always #4 clk = ~clk;

  refresh_sched #(.ROW_BITS(RB), .WARMUP(WARM_T), .PEND_MAX(PMAX),
                  .PAUSE_CYC(PAUSE_T), .INTERVAL_CYC(INT_T)) uut (
    .clk(clk), .rst_n(rst_n), .ref_grant(ref_grant), .ref_done(ref_done),
    .ref_req(ref_req), .ready(ready), .ref_row(ref_row));

  refresh_sched #(.ROW_BITS(RB), .WARMUP(WARM_T), .PEND_MAX(PMAX), .ROW_ADDR_EN(1'b0),
                  .PAUSE_CYC(PAUSE_T), .INTERVAL_CYC(INT_T)) uut_flat (
    .clk(clk), .rst_n(rst_n), .ref_grant(ref_grant), .ref_done(ref_done),
    .ref_req(req_f), .ready(ready_f), .ref_row(row_f));

  function automatic bit model_req();
    if (m_fly) return 1'b0;
    if (m_phase == 1) return m_warm > 0;
    if (m_phase == 2) return m_pend > 0;
    return 1'b0;
  endfunction

  task automatic check(bit ok, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", what, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
      finish_up();
    end
  end

  // reference model, one step per rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_pcnt = 0; m_warm = 0; m_tmr = 0; m_pend = 0; m_row = 0; m_fly = 0;
    end else begin
      bit rq, g, d, tk;
      rq = model_req();
      g  = ref_grant && rq;
      d  = ref_done && m_fly;
      tk = 0;
      if (m_phase == 0) begin
        if (m_pcnt == PAUSE_T - 1) begin m_phase = 1; m_warm = WARM_T; end
        else m_pcnt++;
      end else if (m_phase == 1) begin
        if (d) begin
          m_warm--;
          if (m_warm == 0) begin m_phase = 2; m_tmr = 0; end
        end
      end else begin
        tk = (m_tmr == INT_T - 1);
        m_tmr = tk ? 0 : m_tmr + 1;
        m_pend = m_pend + (tk ? 1 : 0) - (d ? 1 : 0);
        if (m_pend > PMAX) m_pend = PMAX;
      end
      if (g) m_fly = 1;
      else if (d) m_fly = 0;
      if (d) m_row = (m_row + 1) % (1 << RB);
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(ref_req == model_req(), "R3 R5 R6 R7 ref_req", ref_req, model_req());
      check(ready == (m_phase == 2), "R4 ready", ready, m_phase == 2);
      check(ref_row == m_row, "R8 ref_row", ref_row, m_row);
      check(row_f == 0, "R8 ref_row without counter", row_f, 0);
    end
  end

  task automatic serve(int lat, bit noise);
    while (!ref_req) @(negedge clk);
    repeat (lat) @(negedge clk);
    ref_grant = 1'b1;
    @(negedge clk);
    ref_grant = 1'b0;
    if (noise) ref_grant = 1'b1; // R5: grant with no request pending
    @(negedge clk);
    ref_grant = 1'b0;
    ref_done = 1'b1;
    @(negedge clk);
    ref_done = 1'b0;
    served++;
  endtask

  initial begin
    int n;
    // R9: package arithmetic at full-size defaults
    check(us_to_cycles(200, 125) == 25000, "R9 pause cycles", us_to_cycles(200, 125), 25000);
    check(row_spacing_cycles(64000, 4096, 125) == 1953, "R9 4K spacing",
          row_spacing_cycles(64000, 4096, 125), 1953);
    check(row_spacing_cycles(32000, 2048, 125) == 1953, "R9 2K spacing",
          row_spacing_cycles(32000, 2048, 125), 1953);

    repeat (3) @(negedge clk);
    check(ref_req == 0, "R1 reset ref_req", ref_req, 0);
    check(ready == 0, "R1 reset ready", ready, 0);
    check(ref_row == 0, "R1 reset ref_row", ref_row, 0);
    rst_n = 1'b1;

    // R2: quiet for the pause, stray pulses ignored
    for (int i = 0; i < PAUSE_T - 1; i++) begin
      if (i == 4) ref_grant = 1'b1;
      if (i == 6) ref_done = 1'b1;
      @(negedge clk);
      ref_grant = 1'b0;
      ref_done = 1'b0;
      check(ref_req == 0, "R2 no request in pause", ref_req, 0);
    end
    @(negedge clk);
    check(ref_req == 1, "R2 request after pause", ref_req, 1);
    check(ref_row == 0, "R2 stray pulses ignored", ref_row, 0);

    // R3/R4: warm-up burst
    for (int i = 0; i < WARM_T; i++) begin
      check(ready == 0, "R4 not ready during warm-up", ready, 0);
      serve(i % 3, i == 2);
    end
    check(ready == 1, "R4 ready after warm-up", ready, 1);
    check(ref_row == WARM_T % (1 << RB), "R8 row after warm-up", ref_row, WARM_T % (1 << RB));

    // R6: first credit one interval after ready
    for (int i = 0; i < INT_T - 1; i++) begin
      @(negedge clk);
      check(ref_req == 0, "R6 no request before interval", ref_req, 0);
    end
    @(negedge clk);
    check(ref_req == 1, "R6 request at interval", ref_req, 1);

    for (int i = 0; i < 4; i++) serve(i, 1'b0);

    // R7: stall the controller for several intervals
    while (!ref_req) @(negedge clk);
    repeat (5 * INT_T) begin
      @(negedge clk);
      check(ref_req == 1, "R7 request held while stalled", ref_req, 1);
    end
    n = 0;
    while (ref_req) begin
      serve(0, 1'b0);
      n++;
    end
    check(n >= PMAX && n <= PMAX + 1, "R7 saturated credits served", n, PMAX);

    for (int i = 0; i < 3; i++) serve(1, 1'b0);
    @(negedge clk);
    check(ref_row == served % (1 << RB), "R8 row wraps with completions", ref_row, served % (1 << RB));
    check(ready == 1, "R4 ready stays high", ready, 1);
    finish_up();
  end

endmodule